// File: doc/BRIEF.md
# Operating-System Tick Timer

This block gives system software two time bases behind a small register window. A 32-bit stamp counter runs freely and can be overwritten at any time, for instance with zero to restart a measurement. A single down-counting event timer is programmed through one control word. The word's two lowest bits choose whether the timer runs and whether it stops after its first event. The remaining bits hold the count it starts from. When the timer expires it latches a pending flag, and that flag drives the interrupt line until software clears it.

Both counters advance on a common tick. The tick is derived from the clock by a divide-by-`TICK_DIV` prescaler, and a write to the stamp counter restarts the prescaler phase. Software can retrigger the next event at any moment by rewriting the control word. To keep the current mode, it writes the same option bits with a new count.

Top module: `ostmr_top`

## Requirements
- R1: While reset is asserted, every readable register (stamp at address 0, control word at 1, live count at 2, status at 3) reads zero and `irq` is low.
- R2: The stamp counter rises by one on every tick (one tick each `TICK_DIV` clocks) and wraps from all ones to zero. A write at address 0 loads the written value and restarts the tick phase, so that the next tick falls `TICK_DIV` clocks after the write edge.
- R3: A write at address 1 stores the whole word, readable at address 1. The same write loads the live count (address 2) at once with the word's bits 1:0 forced to zero. Bit 0 of the word is the run enable and bit 1 is the one-shot select.
- R4: While bit 0 of the control word is set, the live count drops by one per tick. A tick that finds the count at zero is an expiry and sets the pending flag. So the first expiry happens on tick C+1 after loading a count of C.
- R5: With bit 1 clear (periodic), an expiry reloads the count from the control word, so pending is set again every C+1 ticks.
- R6: With bit 1 set (one-shot), an expiry clears bit 0 of the stored control word. The count then stays at zero and no further expiry occurs.
- R7: Writing zero at address 1 stops the timer and clears the live count. No expiry follows.
- R8: The pending flag is status bit 0. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. An expiry on the same edge as a clear leaves the flag set.
- R9: `irq` is high exactly when status bit 0 reads 1.
- R10: Rewriting the control word while the timer runs discards the old countdown. The next expiry is timed from the new write alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken with `bus_sel` on a clock edge |
| bus_addr | input | 2 | Register index: 0 stamp, 1 control word, 2 live count, 3 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Timer interrupt, the pending flag |

## Verification
The bench builds the block with `DATA_W` = 32 and `TICK_DIV` = 2. A divider of two puts tick edges and bus write edges on different clock phases. Because each timer run starts right after a stamp write has fixed the phase, every expiry lands on an exact cycle of the form (C+1)·2−1 after the control write. The full 32-bit width makes the stamp wrap and the largest count, with its low bits masked, reachable with a single write.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    // Register window, word indexed
    typedef enum logic [1:0] {
        REG_STAMP  = 2'd0,
        REG_CTL    = 2'd1,
        REG_COUNT  = 2'd2,
        REG_STATUS = 2'd3
    } ostmr_reg_e;

    // Option bits inside the control word
    localparam int OPT_EN      = 0;
    localparam int OPT_ONESHOT = 1;
    localparam int OPT_BITS    = 2;

    // Status register bit of the pending flag
    localparam int STAT_PEND   = 0;

endpackage

// File: rtl/ostmr_prescale.sv
module ostmr_prescale #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_direct
            logic unused_restart;
            assign unused_restart = restart;
            assign tick = 1'b1;
        end else begin : g_divided
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

            typedef struct packed {
                logic [PW-1:0] phase;
            } pre_t;

            pre_t st_d, st_q;

            assign tick = (st_q.phase == LAST);

            always_comb begin
                st_d = st_q;
                if (restart) begin
                    st_d.phase = '0;
                end else if (tick) begin
                    st_d.phase = '0;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] value
);

    typedef struct packed {
        logic [DATA_W-1:0] count;
    } stamp_t;

    stamp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.count = load_val;
        end else if (tick) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.count;

endmodule

// File: rtl/ostmr_gtimer.sv
module ostmr_gtimer
    import ostmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctl_wr,
    input  logic              clr_req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_word,
    output logic [DATA_W-1:0] count,
    output logic              pending
);

    localparam logic [DATA_W-1:0] CNT_MASK = {DATA_W{1'b1}} << OPT_BITS;

    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] cnt;
        logic              pend;
    } tmr_t;

    tmr_t st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (ctl_wr) begin
            // new word replaces both the options and the running count
            st_d.ctl = wdata;
            st_d.cnt = wdata & CNT_MASK;
        end else if (tick && st_q.ctl[OPT_EN]) begin
            if (st_q.cnt == '0) begin
                expire = 1'b1;
                if (st_q.ctl[OPT_ONESHOT]) begin
                    st_d.ctl[OPT_EN] = 1'b0;
                end else begin
                    st_d.cnt = st_q.ctl & CNT_MASK;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        // clear first so that a simultaneous expiry wins
        if (clr_req) begin
            st_d.pend = 1'b0;
        end
        if (expire) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_word = st_q.ctl;
    assign count    = st_q.cnt;
    assign pending  = st_q.pend;

endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int TICK_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              wr_any;
    logic              stamp_wr;
    logic              ctl_wr;
    logic              clr_req;
    logic              tick;
    logic [DATA_W-1:0] stamp_val;
    logic [DATA_W-1:0] ctl_val;
    logic [DATA_W-1:0] cnt_val;
    logic              pend_val;

    assign wr_any   = bus_sel && bus_wr;
    assign stamp_wr = wr_any && (ostmr_reg_e'(bus_addr) == REG_STAMP);
    assign ctl_wr   = wr_any && (ostmr_reg_e'(bus_addr) == REG_CTL);
    assign clr_req  = wr_any && (ostmr_reg_e'(bus_addr) == REG_STATUS)
                      && bus_wdata[STAT_PEND];

    ostmr_prescale #(
        .TICK_DIV (TICK_DIV)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (stamp_wr),
        .tick    (tick)
    );

    ostmr_stamp #(
        .DATA_W (DATA_W)
    ) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (stamp_wr),
        .load_val (bus_wdata),
        .value    (stamp_val)
    );

    ostmr_gtimer #(
        .DATA_W (DATA_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctl_wr   (ctl_wr),
        .clr_req  (clr_req),
        .wdata    (bus_wdata),
        .ctl_word (ctl_val),
        .count    (cnt_val),
        .pending  (pend_val)
    );

    always_comb begin
        bus_rdata = '0;
        case (ostmr_reg_e'(bus_addr))
            REG_STAMP:  bus_rdata = stamp_val;
            REG_CTL:    bus_rdata = ctl_val;
            REG_COUNT:  bus_rdata = cnt_val;
            REG_STATUS: bus_rdata[STAT_PEND] = pend_val;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = pend_val;

endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              stamp_wr,
    input logic              ctl_wr,
    input logic              clr_req,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] stamp,
    input logic [DATA_W-1:0] ctl,
    input logic [DATA_W-1:0] cnt,
    input logic              pend
);

    localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} << 2;

    logic run_tick;
    logic expiry;

    assign run_tick = !ctl_wr && tick && ctl[0];
    assign expiry   = run_tick && (cnt == '0);

    a_r2_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stamp_wr && tick) |=> (stamp == $past(stamp) + 1'b1));

    a_r2_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stamp_wr && !tick) |=> $stable(stamp));

    a_r3_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl == $past(wdata)) && (cnt == ($past(wdata) & MASK)));

    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r4_expiry_pends: assert property (@(posedge clk) disable iff (!rst_n)
        expiry |=> pend);

    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expiry && !ctl[1]) |=> (cnt == ($past(ctl) & MASK)));

    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (expiry && ctl[1]) |=> (!ctl[0] && cnt == '0));

    a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !ctl[0]) |=> $stable(cnt));

    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expiry) |=> !pend);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !expiry) |=> !pend);

endmodule

bind ostmr_top ostmr_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .stamp_wr (stamp_wr),
    .ctl_wr   (ctl_wr),
    .clr_req  (clr_req),
    .wdata    (bus_wdata),
    .stamp    (stamp_val),
    .ctl      (ctl_val),
    .cnt      (cnt_val),
    .pend     (pend_val)
);

// File: tb/ostmr_top_tb.sv
`timescale 1ns/1ps
module ostmr_top_tb;

    localparam int W   = 32;
    localparam int DIV = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ostmr_top #(.DATA_W(W), .TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // word, first-event delay in clocks after the control write, period (0 = one-shot)
    localparam logic [95:0] VEC [6] = '{
        {32'h0000_0011, 32'd33, 32'd34},
        {32'h0000_000F, 32'd25, 32'd0},
        {32'h0000_0021, 32'd65, 32'd66},
        {32'h0000_0007, 32'd9,  32'd0},
        {32'h0000_001D, 32'd57, 32'd58},
        {32'h0000_000B, 32'd17, 32'd0}
    };

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d, output int at);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        at = cyc;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // align the tick phase with a stamp write, then program the timer
    task automatic arm(input logic [W-1:0] word, output int at);
        int dummy;
        wr(2'd0, '0, dummy);
        wr(2'd1, word, at);
    endtask

    task automatic wait_irq(input int limit, output int at, output bit seen);
        seen = 1'b0;
        at = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) begin
                seen = 1'b1;
                at = cyc;
                break;
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] d;
        int wa, at, t0;
        bit seen;

        // R1: reset state
        repeat (3) @(posedge clk);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == '0, "R1 reset read", d, '0);
        end
        check(irq == 1'b0, "R1 irq in reset", W'(irq), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // table of timer runs: R4, R5, R6, R3 mask
        for (int v = 0; v < 6; v++) begin
            logic [W-1:0] word, first, period;
            {word, first, period} = VEC[v];
            arm(word, wa);
            wait_irq(400, at, seen);
            check(seen && (at - wa) == int'(first), "R4 first expiry delay",
                  W'(at - wa), first);
            wr(2'd3, 32'h1, t0);
            if (period != 0) begin
                wait_irq(400, t0, seen);
                check(seen && (t0 - at) == int'(period), "R5 periodic spacing",
                      W'(t0 - at), period);
            end else begin
                rd(2'd1, d);
                check(d == (word & ~32'h1), "R6 enable cleared", d, word & ~32'h1);
                wait_irq(3 * int'(first), t0, seen);
                check(!seen, "R6 no second expiry", W'(seen), '0);
            end
            wr(2'd1, '0, t0);
            wr(2'd3, 32'h1, t0);
        end

        // R2: stamp load and count
        wr(2'd0, 32'h100, wa);
        rd(2'd0, d);
        repeat (8) @(negedge clk);
        #1;
        check(bus_rdata == 32'h100 + W'((cyc - wa) / DIV), "R2 stamp count",
              bus_rdata, 32'h100 + W'((cyc - wa) / DIV));
        wr(2'd0, 32'hFFFF_FFFF, wa);
        rd(2'd0, d);
        while (cyc - wa < 5) @(negedge clk);
        #1;
        check(bus_rdata == 32'h1, "R2 stamp wrap", bus_rdata, 32'h1);

        // R3: largest count, masked, loaded at once
        wr(2'd1, 32'hFFFF_FFFD, wa);
        rd(2'd1, d);
        check(d == 32'hFFFF_FFFD, "R3 word readback", d, 32'hFFFF_FFFD);
        wr(2'd1, 32'h0000_00F3, wa);
        rd(2'd2, d);
        check(d == 32'h0000_00F0, "R3 masked count", d, 32'h0000_00F0);

        // R4: count steps per tick
        arm(32'h41, wa);
        rd(2'd2, d);
        while (cyc - wa < 9) @(negedge clk);
        #1;
        check(bus_rdata == 32'd64 - W'((cyc - wa + 1) / DIV), "R4 countdown",
              bus_rdata, 32'd64 - W'((cyc - wa + 1) / DIV));

        // R7: writing zero stops the timer
        wr(2'd1, '0, t0);
        rd(2'd2, d);
        check(d == '0, "R7 count cleared", d, '0);
        wait_irq(200, t0, seen);
        check(!seen, "R7 no expiry after stop", W'(seen), '0);

        // R8 / R9: write-one-to-clear
        arm(32'h0B, wa);
        wait_irq(100, at, seen);
        rd(2'd3, d);
        check(d == 32'h1 && irq, "R9 irq follows status", d, 32'h1);
        wr(2'd3, 32'h0, t0);
        rd(2'd3, d);
        check(d == 32'h1, "R8 write zero keeps flag", d, 32'h1);
        wr(2'd3, 32'h1, t0);
        rd(2'd3, d);
        check(d == '0 && !irq, "R8 write one clears", d, '0);

        // R10: retrigger with a new count
        arm(32'h401, wa);
        repeat (20) @(negedge clk);
        arm(32'h11, wa);
        wait_irq(100, at, seen);
        check(seen && (at - wa) == 33, "R10 retrigger timing", W'(at - wa), 32'd33);
        wr(2'd1, '0, t0);

        finish_run();
    end

endmodule